// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Tracker

This block serves a single processor's interrupt acknowledge and end-of-interrupt (EOI) traffic. An acknowledge takes the interrupt that the pending selector currently offers and, if its priority beats the running priority, makes it the running interrupt. The acknowledged ID is returned, and a pending-clear request goes out for that interrupt. A refused acknowledge returns the spurious ID 1023.

Each acknowledged interrupt remembers which interrupt it preempted. These per-ID links form a preemption stack held in a small table indexed by interrupt ID. An EOI for the running interrupt pops the stack and restores the preempted interrupt and its priority. An EOI for an interrupt deeper in the stack is handled by a multi-cycle walk from the top of the stack, which splices the completed entry out. While the walk runs the block is busy and takes no new requests. A level-sensitive interrupt whose line is still asserted when it completes is requested pending again.

Top module: `ai_tracker`

## Requirements
- R1: An acknowledge is refused when the offered ID is not below NUM_IRQ (1023 means nothing pending) or when the offered priority is not strictly less than the running priority. A refused acknowledge returns 1023, and it leaves the running ID and priority and the pending-clear output unchanged.
- R2: A granted acknowledge returns the offered ID. On the same edge the offered ID becomes the running ID, and the offered priority, zero-extended to 9 bits, becomes the running priority.
- R3: A granted acknowledge raises the pending-clear request for one cycle with the acknowledged ID. The all-processors flag equals the 1:N model flag that was offered with the ID.
- R4: After reset the running ID is 1023 and the running priority is 0x100. Whenever the running ID is 1023, the running priority is 0x100.
- R5: An EOI is ignored when its ID is not below NUM_IRQ (1023 included) or when the running ID is 1023. An ignored EOI changes no state and raises no pending-set request.
- R6: An accepted EOI raises the pending-set request for one cycle with the completed ID only when the interrupt is level-triggered (edge flag 0), enabled, still asserted and targeted at this processor.
- R7: An EOI of the running interrupt makes its recorded link the new running ID. The new running priority is taken from the resume-priority input, or is 0x100 when the link is 1023.
- R8: An EOI of a non-running interrupt raises busy and walks the links from the running interrupt. The entry whose link is the completed ID receives the completed ID's own link, and the walk also ends on a link of 1023. The running ID and priority do not change during or after the walk.
- R9: Requests are accepted only on edges where busy is low. When acknowledge and EOI are requested on the same edge, the EOI is taken first and the acknowledge on a following edge. A request is held until it is accepted.
- R10: The acknowledge result (ack_done, ack_id) and the pending-set and pending-clear pulses appear in the cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hp_id | input | 10 | Highest-pending interrupt ID offered (1023 = none) |
| hp_prio | input | 8 | Priority of hp_id (lower is more urgent) |
| hp_all_cpus | input | 1 | hp_id uses the 1:N model |
| ack_req | input | 1 | Acknowledge request, held until ack_done |
| ack_done | output | 1 | One-cycle pulse: acknowledge served |
| ack_id | output | 10 | Acknowledged ID or 1023 |
| eoi_req | input | 1 | EOI request, taken on an edge with busy low |
| eoi_id | input | 10 | ID being completed |
| eoi_edge | input | 1 | Completed interrupt is edge-triggered |
| eoi_enabled | input | 1 | Completed interrupt is enabled |
| eoi_level | input | 1 | Completed interrupt's line is asserted now |
| eoi_targeted | input | 1 | Completed interrupt targets this processor |
| resume_id | output | 10 | ID that would resume if the running interrupt completed |
| resume_prio | input | 8 | Priority of resume_id, looked up outside |
| run_id | output | 10 | Running interrupt ID (1023 = none) |
| run_prio | output | 9 | Running priority (0x100 = none) |
| busy | output | 1 | Chain walk in progress |
| pset_vld | output | 1 | Pending-set request pulse |
| pset_id | output | 10 | ID to set pending |
| pclr_vld | output | 1 | Pending-clear request pulse |
| pclr_id | output | 10 | ID to clear pending |
| pclr_all | output | 1 | Clear pending for all processors |

## Verification
Acknowledge and completion can be requested on the same edge. The bench raises both together while an interrupt is running and a higher-priority one is offered. It judges the order from the results: no acknowledge result on the first edge, and a running ID of 1023 after it. On the next edge the new interrupt is acknowledged, and its link must read 1023, so a later EOI must leave the block idle rather than resume the old interrupt. The bench also raises an acknowledge during an out-of-order walk and checks that the acknowledge is served only after busy falls.

// File: rtl/ai_pkg.sv
package ai_pkg;
    localparam int ID_W = 10;
    localparam int PRIO_W = 8;
    localparam logic [ID_W-1:0] NONE_ID = 10'd1023;
    localparam logic [PRIO_W:0] IDLE_PRIO = 9'h100;

    typedef struct packed {
        logic            vld;
        logic [ID_W-1:0] id;
        logic            all;
    } pend_req_t;

    typedef enum logic {
        WK_IDLE,
        WK_STEP
    } walk_state_t;

    function automatic logic [PRIO_W:0] widen_prio(input logic [PRIO_W-1:0] p);
        return {1'b0, p};
    endfunction
endpackage

// File: rtl/ai_link_ram.sv
module ai_link_ram
    import ai_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [ID_W-1:0]  wdata,
    input  logic [IDX_W-1:0] ra_addr,
    output logic [ID_W-1:0]  ra_data,
    input  logic [IDX_W-1:0] rb_addr,
    output logic [ID_W-1:0]  rb_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [ID_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= NONE_ID;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];
endmodule

// File: rtl/ai_ack_eval.sv
module ai_ack_eval
    import ai_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic [ID_W-1:0]   hp_id,
    input  logic [PRIO_W-1:0] hp_prio,
    input  logic [PRIO_W:0]   run_prio,
    output logic              grant,
    output logic [ID_W-1:0]   result_id
);
    localparam logic [ID_W-1:0] LIMIT = ID_W'(NUM_IRQ);

    logic real_id;
    logic beats;

    always_comb begin
        real_id   = hp_id < LIMIT;
        beats     = widen_prio(hp_prio) < run_prio;
        grant     = real_id && beats;
        result_id = grant ? hp_id : NONE_ID;
    end
endmodule

// File: rtl/ai_chain_walker.sv
module ai_chain_walker
    import ai_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [ID_W-1:0]  start_head,
    input  logic [ID_W-1:0]  start_tgt,
    input  logic [ID_W-1:0]  start_tgt_link,
    output logic [IDX_W-1:0] rd_idx,
    input  logic [ID_W-1:0]  rd_data,
    output logic             busy,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [ID_W-1:0]  wr_data
);
    walk_state_t     state;
    logic [ID_W-1:0] cur;
    logic [ID_W-1:0] tgt;
    logic [ID_W-1:0] tgt_link;
    logic            hit;
    logic            end_of_chain;

    assign busy         = (state == WK_STEP);
    assign rd_idx       = cur[IDX_W-1:0];
    assign hit          = busy && (rd_data == tgt);
    assign end_of_chain = busy && (rd_data == NONE_ID);
    assign wr_en        = hit;
    assign wr_idx       = cur[IDX_W-1:0];
    assign wr_data      = tgt_link;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= WK_IDLE;
            cur      <= NONE_ID;
            tgt      <= NONE_ID;
            tgt_link <= NONE_ID;
        end else begin
            case (state)
                WK_IDLE: begin
                    if (start) begin
                        state    <= WK_STEP;
                        cur      <= start_head;
                        tgt      <= start_tgt;
                        tgt_link <= start_tgt_link;
                    end
                end
                WK_STEP: begin
                    if (hit || end_of_chain) begin
                        state <= WK_IDLE;
                    end else begin
                        cur <= rd_data;
                    end
                end
                default: state <= WK_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ai_tracker.sv
module ai_tracker
    import ai_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [9:0]  hp_id,
    input  logic [7:0]  hp_prio,
    input  logic        hp_all_cpus,
    input  logic        ack_req,
    output logic        ack_done,
    output logic [9:0]  ack_id,
    input  logic        eoi_req,
    input  logic [9:0]  eoi_id,
    input  logic        eoi_edge,
    input  logic        eoi_enabled,
    input  logic        eoi_level,
    input  logic        eoi_targeted,
    output logic [9:0]  resume_id,
    input  logic [7:0]  resume_prio,
    output logic [9:0]  run_id,
    output logic [8:0]  run_prio,
    output logic        busy,
    output logic        pset_vld,
    output logic [9:0]  pset_id,
    output logic        pclr_vld,
    output logic [9:0]  pclr_id,
    output logic        pclr_all
);
    localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
    localparam logic [ID_W-1:0] LIMIT = ID_W'(NUM_IRQ);

    logic [ID_W-1:0]   run_id_q;
    logic [PRIO_W:0]   run_prio_q;
    logic              ack_done_q;
    logic [ID_W-1:0]   ack_id_q;
    pend_req_t         pset_q;
    pend_req_t         pclr_q;

    logic              walk_busy;
    logic              eoi_take;
    logic              ack_take;
    logic              eoi_real;
    logic              eoi_is_run;
    logic              repend;
    logic              walk_start;
    logic              grant;
    logic [ID_W-1:0]   ack_result;

    logic              ram_we;
    logic [IDX_W-1:0]  ram_waddr;
    logic [ID_W-1:0]   ram_wdata;
    logic [ID_W-1:0]   link_of_run;
    logic [IDX_W-1:0]  rb_addr;
    logic [ID_W-1:0]   rb_data;
    logic              wk_wr_en;
    logic [IDX_W-1:0]  wk_wr_idx;
    logic [ID_W-1:0]   wk_wr_data;
    logic [IDX_W-1:0]  wk_rd_idx;

    // Request arbitration: a walk blocks both, EOI wins a collision.
    always_comb begin
        eoi_take   = eoi_req && !walk_busy;
        ack_take   = ack_req && !walk_busy && !eoi_req;
        eoi_real   = (eoi_id < LIMIT) && (run_id_q != NONE_ID);
        eoi_is_run = (eoi_id == run_id_q);
        repend     = !eoi_edge && eoi_enabled && eoi_level && eoi_targeted;
        walk_start = eoi_take && eoi_real && !eoi_is_run;
    end

    ai_ack_eval #(
        .NUM_IRQ(NUM_IRQ)
    ) u_eval (
        .hp_id     (hp_id),
        .hp_prio   (hp_prio),
        .run_prio  (run_prio_q),
        .grant     (grant),
        .result_id (ack_result)
    );

    // Single write port: walker splice or link recorded by an acknowledge.
    always_comb begin
        if (wk_wr_en) begin
            ram_we    = 1'b1;
            ram_waddr = wk_wr_idx;
            ram_wdata = wk_wr_data;
        end else begin
            ram_we    = ack_take && grant;
            ram_waddr = hp_id[IDX_W-1:0];
            ram_wdata = run_id_q;
        end
        rb_addr = walk_busy ? wk_rd_idx : eoi_id[IDX_W-1:0];
    end

    ai_link_ram #(
        .IDX_W(IDX_W)
    ) u_links (
        .clk     (clk),
        .rst     (rst),
        .we      (ram_we),
        .waddr   (ram_waddr),
        .wdata   (ram_wdata),
        .ra_addr (run_id_q[IDX_W-1:0]),
        .ra_data (link_of_run),
        .rb_addr (rb_addr),
        .rb_data (rb_data)
    );

    ai_chain_walker #(
        .IDX_W(IDX_W)
    ) u_walk (
        .clk            (clk),
        .rst            (rst),
        .start          (walk_start),
        .start_head     (run_id_q),
        .start_tgt      (eoi_id),
        .start_tgt_link (rb_data),
        .rd_idx         (wk_rd_idx),
        .rd_data        (rb_data),
        .busy           (walk_busy),
        .wr_en          (wk_wr_en),
        .wr_idx         (wk_wr_idx),
        .wr_data        (wk_wr_data)
    );

    assign resume_id = (run_id_q == NONE_ID) ? NONE_ID : link_of_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_id_q   <= NONE_ID;
            run_prio_q <= IDLE_PRIO;
            ack_done_q <= 1'b0;
            ack_id_q   <= NONE_ID;
            pset_q     <= '{vld: 1'b0, id: NONE_ID, all: 1'b0};
            pclr_q     <= '{vld: 1'b0, id: NONE_ID, all: 1'b0};
        end else begin
            ack_done_q <= ack_take;
            pset_q.vld <= 1'b0;
            pclr_q.vld <= 1'b0;
            if (ack_take) begin
                ack_id_q <= ack_result;
                if (grant) begin
                    run_id_q   <= hp_id;
                    run_prio_q <= widen_prio(hp_prio);
                    pclr_q     <= '{vld: 1'b1, id: hp_id, all: hp_all_cpus};
                end
            end
            if (eoi_take && eoi_real) begin
                if (repend) begin
                    pset_q <= '{vld: 1'b1, id: eoi_id, all: 1'b0};
                end
                if (eoi_is_run) begin
                    run_id_q   <= resume_id;
                    run_prio_q <= (resume_id == NONE_ID) ? IDLE_PRIO
                                                         : widen_prio(resume_prio);
                end
            end
        end
    end

    assign run_id   = run_id_q;
    assign run_prio = run_prio_q;
    assign ack_done = ack_done_q;
    assign ack_id   = ack_id_q;
    assign busy     = walk_busy;
    assign pset_vld = pset_q.vld;
    assign pset_id  = pset_q.id;
    assign pclr_vld = pclr_q.vld;
    assign pclr_id  = pclr_q.id;
    assign pclr_all = pclr_q.all;
endmodule

// File: rtl/ai_tracker_chk.sv
module ai_tracker_chk #(
    parameter int NUM_IRQ = 64
) (
    input logic       clk,
    input logic       rst,
    input logic       ack_done,
    input logic [9:0] ack_id,
    input logic [9:0] run_id,
    input logic [8:0] run_prio,
    input logic       busy,
    input logic       pset_vld,
    input logic [9:0] pset_id,
    input logic       pclr_vld,
    input logic [9:0] pclr_id
);
    localparam logic [9:0] LIM = 10'(NUM_IRQ);

    // R4: idle running ID always pairs with the idle priority
    a_r4_idle_prio: assert property (@(posedge clk) disable iff (rst)
        (run_id == 10'd1023) |-> (run_prio == 9'h100));

    // R4: a real running ID never carries the idle priority
    a_r4_busy_prio: assert property (@(posedge clk) disable iff (rst)
        (run_id != 10'd1023) |-> (run_prio < 9'h100));

    // R1: a spurious result leaves the running ID alone and clears nothing
    a_r1_spurious_keeps_run: assert property (@(posedge clk) disable iff (rst)
        (ack_done && ack_id == 10'd1023) |-> (run_id == $past(run_id) && !pclr_vld));

    // R2: a granted acknowledge is running when its result appears
    a_r2_ack_runs: assert property (@(posedge clk) disable iff (rst)
        (ack_done && ack_id != 10'd1023) |-> (run_id == ack_id));

    // R3: a pending clear only accompanies a granted acknowledge of the same ID
    a_r3_clr_matches: assert property (@(posedge clk) disable iff (rst)
        pclr_vld |-> (ack_done && pclr_id == ack_id));

    // R5: a re-pend request only follows an EOI taken while something ran
    a_r5_pset_real: assert property (@(posedge clk) disable iff (rst)
        pset_vld |-> ($past(run_id) != 10'd1023 && pset_id < LIM));

    // R8: the running interrupt is untouched across walk cycles
    a_r8_walk_keeps_run: assert property (@(posedge clk) disable iff (rst)
        $past(busy) |-> (run_id == $past(run_id)));

    // R9: no acknowledge is served on an edge while busy
    a_r9_ack_waits: assert property (@(posedge clk) disable iff (rst)
        busy |=> !ack_done);
endmodule

bind ai_tracker ai_tracker_chk #(
    .NUM_IRQ(NUM_IRQ)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ack_done (ack_done),
    .ack_id   (ack_id),
    .run_id   (run_id),
    .run_prio (run_prio),
    .busy     (busy),
    .pset_vld (pset_vld),
    .pset_id  (pset_id),
    .pclr_vld (pclr_vld),
    .pclr_id  (pclr_id)
);

// File: tb/sim_ai_tracker.sv
`timescale 1ns/1ps
module sim_ai_tracker;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] hp_id = 10'd1023;
    logic [7:0] hp_prio = 8'h00;
    logic       hp_all_cpus = 1'b0;
    logic       ack_req = 1'b0;
    logic       ack_done;
    logic [9:0] ack_id;
    logic       eoi_req = 1'b0;
    logic [9:0] eoi_id = 10'd1023;
    logic       eoi_edge = 1'b0;
    logic       eoi_enabled = 1'b0;
    logic       eoi_level = 1'b0;
    logic       eoi_targeted = 1'b0;
    logic [9:0] resume_id;
    logic [7:0] resume_prio;
    logic [9:0] run_id;
    logic [8:0] run_prio;
    logic       busy;
    logic       pset_vld;
    logic [9:0] pset_id;
    logic       pclr_vld;
    logic [9:0] pclr_id;
    logic       pclr_all;

    int checks = 0;
    int fails = 0;
    logic [7:0] prio_tbl [64];

    always #4 clk = ~clk;

    assign resume_prio = (resume_id < 10'd64) ? prio_tbl[resume_id[5:0]] : 8'h00;

    ai_tracker #(.NUM_IRQ(64)) u0 (
        .clk(clk), .rst(rst), .hp_id(hp_id), .hp_prio(hp_prio),
        .hp_all_cpus(hp_all_cpus), .ack_req(ack_req), .ack_done(ack_done),
        .ack_id(ack_id), .eoi_req(eoi_req), .eoi_id(eoi_id), .eoi_edge(eoi_edge),
        .eoi_enabled(eoi_enabled), .eoi_level(eoi_level), .eoi_targeted(eoi_targeted),
        .resume_id(resume_id), .resume_prio(resume_prio), .run_id(run_id),
        .run_prio(run_prio), .busy(busy), .pset_vld(pset_vld), .pset_id(pset_id),
        .pclr_vld(pclr_vld), .pclr_id(pclr_id), .pclr_all(pclr_all)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_ack(input logic [9:0] id, input logic [7:0] pr, input logic all);
        @(negedge clk);
        hp_id = id; hp_prio = pr; hp_all_cpus = all; ack_req = 1'b1;
        for (int n = 0; n < 20; n++) begin
            @(posedge clk); #1;
            if (ack_done) break;
        end
        ack_req = 1'b0;
    endtask

    task automatic do_eoi(input logic [9:0] id, input logic edg, input logic en,
                          input logic lvl, input logic tgt);
        @(negedge clk);
        for (int n = 0; n < 50 && busy; n++) @(negedge clk);
        eoi_id = id; eoi_edge = edg; eoi_enabled = en; eoi_level = lvl;
        eoi_targeted = tgt; eoi_req = 1'b1;
        @(posedge clk); #1;
        eoi_req = 1'b0;
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 100 && busy; n++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic t_reset();
        chk("R4", "reset run_id", run_id, 10'd1023);
        chk("R4", "reset run_prio", run_prio, 9'h100);
        chk("R4", "reset busy", busy, 0);
        chk("R10", "reset ack_done", ack_done, 0);
    endtask

    task automatic t_ack_sequence();
        do_ack(10'd1023, 8'h00, 1'b0);
        chk("R1", "nothing pending ack_id", ack_id, 10'd1023);
        chk("R1", "nothing pending run_id", run_id, 10'd1023);
        do_ack(10'd5, 8'h80, 1'b0);
        chk("R2", "grant ack_id", ack_id, 10'd5);
        chk("R2", "grant run_id", run_id, 10'd5);
        chk("R2", "grant run_prio", run_prio, 9'h080);
        chk("R3", "clr valid", pclr_vld, 1);
        chk("R3", "clr id", pclr_id, 10'd5);
        chk("R3", "clr all", pclr_all, 0);
        @(posedge clk); #1;
        chk("R10", "clr pulse ends", pclr_vld, 0);
        do_ack(10'd7, 8'h80, 1'b0);
        chk("R1", "equal prio ack_id", ack_id, 10'd1023);
        chk("R1", "equal prio run_id", run_id, 10'd5);
        chk("R1", "equal prio no clr", pclr_vld, 0);
        do_ack(10'd9, 8'h40, 1'b1);
        chk("R2", "nest run_id", run_id, 10'd9);
        chk("R3", "clr all for 1:N", pclr_all, 1);
        do_ack(10'd3, 8'h20, 1'b0);
        chk("R2", "nest2 run_prio", run_prio, 9'h020);
        chk("R7", "resume id of 3", resume_id, 10'd9);
    endtask

    task automatic t_eoi_ignored();
        do_eoi(10'd100, 1'b0, 1'b1, 1'b1, 1'b1);
        chk("R5", "out of range run_id", run_id, 10'd3);
        chk("R5", "out of range no pset", pset_vld, 0);
        chk("R5", "out of range no walk", busy, 0);
        do_eoi(10'd1023, 1'b0, 1'b1, 1'b1, 1'b1);
        chk("R5", "spurious eoi run_id", run_id, 10'd3);
        chk("R5", "spurious eoi no pset", pset_vld, 0);
    endtask

    task automatic t_out_of_order();
        // chain 3 -> 9 -> 5 -> 1023; complete 9 while 3 runs
        do_eoi(10'd9, 1'b0, 1'b1, 1'b1, 1'b1);
        chk("R6", "level repend valid", pset_vld, 1);
        chk("R6", "level repend id", pset_id, 10'd9);
        chk("R8", "walk busy", busy, 1);
        chk("R8", "walk keeps run", run_id, 10'd3);
        hp_id = 10'd2; hp_prio = 8'h01; hp_all_cpus = 1'b0; ack_req = 1'b1;
        @(posedge clk); #1;
        chk("R9", "ack held while busy", ack_done, 0);
        chk("R8", "walk done", busy, 0);
        chk("R8", "run after walk", run_id, 10'd3);
        chk("R8", "prio after walk", run_prio, 9'h020);
        @(posedge clk); #1;
        chk("R9", "ack served after walk", ack_done, 1);
        chk("R9", "ack id after walk", ack_id, 10'd2);
        ack_req = 1'b0;
        do_eoi(10'd2, 1'b1, 1'b1, 1'b1, 1'b1);
        chk("R6", "edge no repend", pset_vld, 0);
        chk("R7", "pop to 3", run_id, 10'd3);
        chk("R7", "pop prio", run_prio, 9'h020);
        chk("R8", "spliced link", resume_id, 10'd5);
        do_eoi(10'd3, 1'b0, 1'b0, 1'b1, 1'b1);
        chk("R6", "disabled no repend", pset_vld, 0);
        chk("R7", "pop to 5", run_id, 10'd5);
        chk("R7", "pop prio 5", run_prio, 9'h080);
        do_eoi(10'd5, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R7", "pop to idle", run_id, 10'd1023);
        chk("R4", "idle prio", run_prio, 9'h100);
        do_eoi(10'd5, 1'b0, 1'b1, 1'b1, 1'b1);
        chk("R5", "idle eoi no pset", pset_vld, 0);
        chk("R5", "idle eoi run", run_id, 10'd1023);
    endtask

    task automatic t_collision();
        do_ack(10'd4, 8'h10, 1'b0);
        chk("R2", "setup run 4", run_id, 10'd4);
        @(negedge clk);
        hp_id = 10'd6; hp_prio = 8'h08; hp_all_cpus = 1'b0; ack_req = 1'b1;
        eoi_id = 10'd4; eoi_edge = 1'b1; eoi_enabled = 1'b0;
        eoi_level = 1'b0; eoi_targeted = 1'b0; eoi_req = 1'b1;
        @(posedge clk); #1;
        eoi_req = 1'b0;
        chk("R9", "eoi first no ack", ack_done, 0);
        chk("R9", "eoi first run idle", run_id, 10'd1023);
        @(posedge clk); #1;
        chk("R9", "ack second", ack_done, 1);
        chk("R9", "ack second id", ack_id, 10'd6);
        ack_req = 1'b0;
        chk("R9", "link of 6 empty", resume_id, 10'd1023);
        do_eoi(10'd6, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R9", "after 6 idle", run_id, 10'd1023);
        chk("R4", "after 6 prio", run_prio, 9'h100);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) prio_tbl[i] = 8'hff;
        prio_tbl[2] = 8'h01; prio_tbl[3] = 8'h20; prio_tbl[4] = 8'h10;
        prio_tbl[5] = 8'h80; prio_tbl[6] = 8'h08; prio_tbl[9] = 8'h40;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_ack_sequence();
        t_eoi_ignored();
        t_out_of_order();
        wait_idle();
        t_collision();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule